// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a register-mapped controller for a group of 32 general-purpose pins. Each pin has a direction bit. Output levels change only through a write-ones-to-set port and a write-ones-to-clear port, so software never has to do a read-modify-write. Every pin input passes through a two-stage synchronizer. The synchronized level can be read back whether the pin is an input or an output.

A rising or falling edge on the synchronized level latches a bit in an event status register, but only when that edge is enabled for that pin. Rising and falling enables each have their own set and clear ports. Software clears status bits by writing ones. The pins are split into a low half and a high half. Each half drives its own interrupt line, and each line is gated by its own bank enable bit.

The bus is a simple synchronous port with a byte address, a write strobe and a read strobe. Read data is registered and appears in the cycle after the read strobe. Address bits 1:0 are ignored. Word offsets: 0x08 bank enable, 0x10 direction, 0x14 output set, 0x18 output clear, 0x1C input level, 0x20 rise-enable set, 0x24 rise-enable clear, 0x28 fall-enable set, 0x2C fall-enable clear, 0x30 event status.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every direction bit is 1 (all pins inputs, `pin_oe` all 0). Output levels, both edge enables, event status and both bank enables are 0.
- R2: The direction register at 0x10 reads back as written. A 1 makes that pin an input and a 0 makes it an output, so `pin_oe` is the bitwise inverse of the register.
- R3: Writing 0x14 sets to 1 every output bit whose data bit is 1 and leaves the other bits unchanged. Reads of 0x14 return the current output levels.
- R4: Writing 0x18 clears to 0 every output bit whose data bit is 1 and leaves the other bits unchanged. Reads of 0x18 return the current output levels.
- R5: A read of 0x1C returns the input level after two flops. A pin change made just before a read is not yet visible in that read, but it is visible two clock cycles later. This holds for pins set as outputs too.
- R6: Rising-edge enables are set by writing ones to 0x20 and cleared by writing ones to 0x24. Both addresses read back the enable vector. An enabled rising edge sets that pin's status bit.
- R7: Falling-edge enables use 0x28 (set) and 0x2C (clear) in the same way. With both enables on, a pin records both edges.
- R8: An edge whose enable is off leaves the status bit at 0.
- R9: Writing ones to 0x30 clears those status bits. Zero bits are kept. If an edge event and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: `irq[0]` is the OR of status bits 15:0 gated by bank enable bit 0. `irq[1]` is the OR of bits 31:16 gated by bank enable bit 1. Bank enable at 0x08 stores only bits 1:0, so writing 0x1F enables both banks.
- R11: Read data is registered: it appears one cycle after the read strobe. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Raw pin levels (asynchronous) |
| pin_out | output | 32 | Output levels |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| irq | output | 2 | Per-bank interrupt lines |

## Verification
The bench drives an edge into the same cycle as a status clear on that bit. A clear-wins design would lose the event, and the event would never come back. It reads the input level right after a pin change and again two cycles later, which catches a missing synchronizer stage or an extra one. It toggles pins whose edge enables are off and checks that status stays zero, which a design that ignores the enables would fail. It also sets status in one half while only the other half's bank is enabled, which exposes swapped or ungated interrupt lines.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int PIN_COUNT  = 32;
    localparam int HALF_WIDTH = 16;
    localparam int ADDR_BITS  = 6;
    localparam int IDX_BITS   = ADDR_BITS - 2;

    typedef enum logic [IDX_BITS-1:0] {
        RG_BANK_EN  = 4'h2,
        RG_DIR      = 4'h4,
        RG_OUT_SET  = 4'h5,
        RG_OUT_CLR  = 4'h6,
        RG_LEVEL    = 4'h7,
        RG_RISE_SET = 4'h8,
        RG_RISE_CLR = 4'h9,
        RG_FALL_SET = 4'hA,
        RG_FALL_CLR = 4'hB,
        RG_STATUS   = 4'hC
    } reg_idx_e;

    function automatic logic [IDX_BITS-1:0] word_index(input logic [ADDR_BITS-1:0] a);
        return a[ADDR_BITS-1:2];
    endfunction

    function automatic logic hit(input logic [IDX_BITS-1:0] idx, input reg_idx_e which);
        return idx == which;
    endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] stage1;
    logic [N-1:0] stage2;
    logic [N-1:0] prior;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            prior  <= '0;
        end else begin
            stage1 <= pin_in;
            stage2 <= stage1;
            prior  <= stage2;
        end
    end

    assign level = stage2;
    assign rise  = stage2 & ~prior;
    assign fall  = ~stage2 & prior;

    // R5: the visible level trails the first stage by exactly one cycle
    a_r5_two_stage: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (level == $past(stage1)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int N  = 32,
    parameter int NB = 2,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [N-1:0]  bus_wdata,
    input  logic          bus_rd,
    output logic [N-1:0]  bus_rdata,
    input  logic [N-1:0]  level,
    input  logic [N-1:0]  rise,
    input  logic [N-1:0]  fall,
    output logic [N-1:0]  dir_q,
    output logic [N-1:0]  out_q,
    output logic [N-1:0]  status_q,
    output logic [NB-1:0] bank_en_q
);
    logic [IDX_BITS-1:0] idx;
    logic [N-1:0] rise_en_q, fall_en_q;
    logic [N-1:0] st_clr, st_set;
    logic [N-1:0] rmux;

    assign idx = word_index(bus_addr);

    function automatic logic [N-1:0] w1_mask(input logic wr, input logic sel, input logic [N-1:0] d);
        return (wr && sel) ? d : '0;
    endfunction

    assign st_clr = w1_mask(bus_wr, hit(idx, RG_STATUS), bus_wdata);
    assign st_set = (rise & rise_en_q) | (fall & fall_en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q     <= '1;
            out_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
            status_q  <= '0;
            bank_en_q <= '0;
        end else begin
            if (bus_wr && hit(idx, RG_DIR))
                dir_q <= bus_wdata;
            if (bus_wr && hit(idx, RG_BANK_EN))
                bank_en_q <= bus_wdata[NB-1:0];
            out_q <= (out_q | w1_mask(bus_wr, hit(idx, RG_OUT_SET), bus_wdata))
                   & ~w1_mask(bus_wr, hit(idx, RG_OUT_CLR), bus_wdata);
            rise_en_q <= (rise_en_q | w1_mask(bus_wr, hit(idx, RG_RISE_SET), bus_wdata))
                       & ~w1_mask(bus_wr, hit(idx, RG_RISE_CLR), bus_wdata);
            fall_en_q <= (fall_en_q | w1_mask(bus_wr, hit(idx, RG_FALL_SET), bus_wdata))
                       & ~w1_mask(bus_wr, hit(idx, RG_FALL_CLR), bus_wdata);
            status_q <= (status_q & ~st_clr) | st_set;
        end
    end

    always_comb begin
        rmux = '0;
        case (idx)
            RG_BANK_EN:               rmux[NB-1:0] = bank_en_q;
            RG_DIR:                   rmux = dir_q;
            RG_OUT_SET, RG_OUT_CLR:   rmux = out_q;
            RG_LEVEL:                 rmux = level;
            RG_RISE_SET, RG_RISE_CLR: rmux = rise_en_q;
            RG_FALL_SET, RG_FALL_CLR: rmux = fall_en_q;
            RG_STATUS:                rmux = status_q;
            default:                  rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rmux;
    end

    // R1: reset returns the configuration to its idle values
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (dir_q == '1 && out_q == '0 && status_q == '0 && bank_en_q == '0));

    // R9: a status bit only drops when a clear was written for it
    a_r9_status_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status_q) & ~$past(st_clr)) & ~status_q) == '0));

    // R8: a newly set status bit needs an enabled edge in the cycle before
    a_r8_status_cause: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q)
                   & ~$past((rise & rise_en_q) | (fall & fall_en_q))) == '0));

endmodule

// File: rtl/gpio_irq_banks.sv
module gpio_irq_banks #(
    parameter int N  = 32,
    parameter int BW = 16,
    parameter int NB = N / BW
) (
    input  logic [N-1:0]  status,
    input  logic [NB-1:0] bank_en,
    output logic [NB-1:0] irq
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign irq[b] = bank_en[b] & (|status[b*BW +: BW]);
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NPINS  = PIN_COUNT,
    parameter int BANK_W = HALF_WIDTH,
    parameter int AW     = ADDR_BITS,
    localparam int NB    = NPINS / BANK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [NPINS-1:0] bus_wdata,
    input  logic             bus_rd,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NB-1:0]    irq
);
    logic [NPINS-1:0] level, rise, fall;
    logic [NPINS-1:0] dir_q, status_q;
    logic [NB-1:0]    bank_en_q;

    gpio_sync_edge #(.N(NPINS)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .level(level), .rise(rise), .fall(fall)
    );

    gpio_regs #(.N(NPINS), .NB(NB), .AW(AW)) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .level(level), .rise(rise), .fall(fall),
        .dir_q(dir_q), .out_q(pin_out), .status_q(status_q), .bank_en_q(bank_en_q)
    );

    gpio_irq_banks #(.N(NPINS), .BW(BANK_W), .NB(NB)) u_irq (
        .status(status_q), .bank_en(bank_en_q), .irq(irq)
    );

    assign pin_oe = ~dir_q;

    // R10: an interrupt line is only raised while its bank is enabled
    for (genvar b = 0; b < NB; b++) begin : g_chk
        a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
            irq[b] |-> (bank_en_q[b] && (status_q[b*BANK_W +: BANK_W] != '0)));
    end

endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [1:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [5:0] A_BANK = 6'h08, A_DIR = 6'h10, A_OSET = 6'h14, A_OCLR = 6'h18,
                           A_LVL = 6'h1C, A_RSET = 6'h20, A_RCLR = 6'h24,
                           A_FSET = 6'h28, A_FCLR = 6'h2C, A_STAT = 6'h30;

    always #10 clk = ~clk;

    gpio_edge_ctrl i_gpio_edge_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 irq", {30'h0, irq}, 32'h0);
        rd(A_DIR, v);  check("R1 dir", v, 32'hFFFF_FFFF);
        rd(A_STAT, v); check("R1 status", v, 32'h0);
        rd(A_RSET, v); check("R1 rise enables", v, 32'h0);
        rd(A_FSET, v); check("R1 fall enables", v, 32'h0);
        rd(A_BANK, v); check("R1 bank enables", v, 32'h0);
    endtask

    task automatic t_direction();
        logic [31:0] v;
        wr(A_DIR, 32'h0F0F_00FF);
        rd(A_DIR, v); check("R2 dir readback", v, 32'h0F0F_00FF);
        check("R2 pin_oe", pin_oe, 32'hF0F0_FF00);
        wr(A_DIR, 32'hFFFF_FFFF);
        check("R2 pin_oe all inputs", pin_oe, 32'h0);
    endtask

    task automatic t_output();
        logic [31:0] v;
        wr(A_OSET, 32'h8000_0011);
        check("R3 set", pin_out, 32'h8000_0011);
        wr(A_OSET, 32'h0000_0100);
        check("R3 zero bits keep", pin_out, 32'h8000_0111);
        rd(A_OSET, v); check("R3 readback", v, 32'h8000_0111);
        wr(A_OCLR, 32'h8000_0001);
        check("R4 clear", pin_out, 32'h0000_0110);
        rd(A_OCLR, v); check("R4 readback", v, 32'h0000_0110);
        wr(A_OCLR, 32'hFFFF_FFFF);
        check("R4 clear all", pin_out, 32'h0);
    endtask

    task automatic t_input_sync();
        logic [31:0] v;
        wr(A_DIR, 32'hFFFF_FFFE);
        pin_in = 32'h0000_0001;
        rd(A_LVL, v); check("R5 not yet visible", v, 32'h0);
        rd(A_LVL, v); check("R5 visible after two flops", v, 32'h0000_0001);
        pin_in = 32'h0;
        settle();
        wr(A_DIR, 32'hFFFF_FFFF);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(A_RSET, 32'h0010_0008);
        rd(A_RCLR, v); check("R6 rise enable readback", v, 32'h0010_0008);
        pin_in = 32'h0000_0008; settle();
        rd(A_STAT, v); check("R6 rise latched", v, 32'h0000_0008);
        pin_in = 32'h0; settle();
        rd(A_STAT, v); check("R6 fall not recorded", v, 32'h0000_0008);
        wr(A_STAT, 32'h0000_0008);
        rd(A_STAT, v); check("R9 w1c clears", v, 32'h0);
    endtask

    task automatic t_fall_both();
        logic [31:0] v;
        wr(A_FSET, 32'h0000_0080);
        wr(A_RSET, 32'h0000_0080);
        rd(A_FCLR, v); check("R7 fall enable readback", v, 32'h0000_0080);
        pin_in = 32'h0000_0080; settle();
        rd(A_STAT, v); check("R7 both: rise", v, 32'h0000_0080);
        wr(A_STAT, 32'h0000_0080);
        pin_in = 32'h0; settle();
        rd(A_STAT, v); check("R7 both: fall", v, 32'h0000_0080);
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        wr(A_RCLR, 32'hFFFF_FFFF);
        wr(A_FCLR, 32'hFFFF_FFFF);
        rd(A_RSET, v); check("R6 rise clear port", v, 32'h0);
        pin_in = 32'h00FF_0F08; settle();
        pin_in = 32'h0; settle();
        rd(A_STAT, v); check("R8 disabled edges ignored", v, 32'h0);
    endtask

    task automatic t_w1c_priority();
        logic [31:0] v;
        wr(A_RSET, 32'h0000_0021);
        pin_in = 32'h0000_0020; settle();
        rd(A_STAT, v); check("R9 prior bit set", v, 32'h0000_0020);
        @(negedge clk); pin_in = 32'h0000_0021;
        @(negedge clk);
        @(negedge clk);
        bus_addr = A_STAT; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(A_STAT, v); check("R9 set beats clear", v, 32'h0000_0001);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); check("R9 cleared afterwards", v, 32'h0);
        pin_in = 32'h0; settle();
        wr(A_RCLR, 32'hFFFF_FFFF);
    endtask

    task automatic t_bank_irq();
        logic [31:0] v;
        wr(A_RSET, 32'h0010_0004);
        pin_in = 32'h0010_0004; settle();
        check("R10 irq off when banks disabled", {30'h0, irq}, 32'h0);
        wr(A_BANK, 32'h1);
        check("R10 low bank only", {30'h0, irq}, 32'h1);
        wr(A_BANK, 32'h2);
        check("R10 high bank only", {30'h0, irq}, 32'h2);
        wr(A_BANK, 32'h1F);
        check("R10 both banks", {30'h0, irq}, 32'h3);
        rd(A_BANK, v); check("R10 bank enable width", v, 32'h3);
        wr(A_STAT, 32'h0000_0004);
        check("R10 low cleared", {30'h0, irq}, 32'h2);
        wr(A_STAT, 32'h0010_0000);
        check("R10 high cleared", {30'h0, irq}, 32'h0);
        pin_in = 32'h0; settle();
    endtask

    task automatic t_read_path();
        logic [31:0] v;
        wr(A_OSET, 32'hA5A5_0000);
        rd(6'h00, v); check("R11 unmapped reads zero", v, 32'h0);
        rd(6'h3C, v); check("R11 unmapped high reads zero", v, 32'h0);
        @(negedge clk); bus_addr = A_OSET;
        @(negedge clk);
        check("R11 no strobe holds data", bus_rdata, 32'h0);
        rd(6'h17, v); check("R11 low address bits ignored", v, 32'hA5A5_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direction();
        t_output();
        t_input_sync();
        t_rise();
        t_fall_both();
        t_disabled();
        t_w1c_priority();
        t_bank_irq();
        t_read_path();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule